// File: doc/BRIEF.md
# Carry-Save Tree Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits each and gives the full `2W`-bit product. An AND array forms one shifted partial product for each multiplier bit. The partial products then pass through a tree of 3:2 carry-save layers. Each layer packs every group of three operands into two, and any operand left over in a layer moves on to the next layer unchanged. Once two operands remain, a single ripple carry-propagate adder merges them.

The tree depth grows with the logarithm of `W`, not linearly as in a row-by-row array. The parameter `REG_OUT` picks how the result leaves the block. With `REG_OUT=1` the product passes through one output register that has a synchronous active-high reset. With `REG_OUT=0` the path is purely combinational.

Top module: `wtree_mult`

## Requirements
- R1: `p` equals the unsigned product of `a` and `b`, with all `2W` bits kept.
- R2: Partial product k is `a` gated by `b[k]` and shifted left by k places. When `b` has only bit k set, `p` equals `a` shifted left by k.
- R3: Each 3:2 cell gives a sum vector that is the bitwise parity of its three inputs and a carry vector that is their bitwise majority shifted one place up. The two outputs add up to the same value as the three inputs.
- R4: A layer that takes n operands passes on 2·floor(n/3) + (n mod 3) operands, and the leftover operands go through unchanged. For example, a 4-bit multiplier reduces 4 → 3 → 2 and an 8-bit multiplier reduces 8 → 6 → 4 → 3 → 2.
- R5: No carry is lost. When both operands are all ones, `p` equals (2^W−1)².
- R6: With `REG_OUT=1`, `p` shows the product of the inputs sampled at the previous rising clock edge. With `REG_OUT=0`, `p` follows the inputs within the same cycle.
- R7: With `REG_OUT=1`, `p` is 0 after any clock edge at which `rst` is high. With `REG_OUT=0`, `rst` has no effect on `p`.
- R8: When either operand is zero, `p` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | W | Multiplicand, unsigned |
| b | input | W | Multiplier, unsigned |
| p | output | 2W | Product, unsigned |

## Verification
Every 4×4 operand pair is applied to a combinational instance. That tree has one layer where an operand passes through unchanged, so any error in the leftover routing or in bit alignment shows up there. Random 8×8 and 16×16 pairs from a fixed seed test the deeper registered trees, including the one-cycle latency.

Directed single-bit multipliers isolate each partial-product row. All-ones operands give the longest carry chains and detect any dropped top carry. Zero operands and a reset applied in the middle of a run show that the register clears, while the combinational instance ignores `rst`.

// File: rtl/wt_pkg.sv
package wt_pkg;
  // operands produced by one 3:2 layer fed with n operands
  function automatic int ops_next(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // number of layers needed to reach two operands
  function automatic int num_layers(input int n);
    int k, c;
    k = 0;
    c = n;
    while (c > 2) begin
      c = ops_next(c);
      k++;
    end
    return k;
  endfunction

  // operand count entering layer l
  function automatic int ops_at(input int n, input int l);
    int c;
    c = n;
    for (int i = 0; i < l; i++) c = ops_next(c);
    return c;
  endfunction

  // start (in operands) of layer l inside the flat operand pool
  function automatic int pool_off(input int n, input int l);
    int s;
    s = 0;
    for (int i = 0; i < l; i++) s += ops_at(n, i);
    return s;
  endfunction
endpackage

// File: rtl/wt_ppgen.sv
module wt_ppgen #(
  parameter int W  = 8,
  parameter int PW = 2 * W
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic [W*PW-1:0]   pp
);
  for (genvar k = 0; k < W; k++) begin : g_row
    logic [PW-1:0] row;
    assign row = PW'({W{b[k]}} & a) << k;
    assign pp[k*PW +: PW] = row;

    // R2: a row carries nothing outside columns k..k+W-1
    localparam logic [PW-1:0] OUTSIDE = ~(PW'({W{1'b1}}) << k);
    always_comb begin
      if (!$isunknown({a, b}))
        assert_row_align_R2: assert ((row & OUTSIDE) == '0);
    end
  end
endmodule

// File: rtl/wt_csa_row.sv
module wt_csa_row #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  input  logic [PW-1:0] z,
  output logic [PW-1:0] s,
  output logic [PW-1:0] c
);
  logic [PW-1:0] maj;

  assign s   = x ^ y ^ z;
  assign maj = (x & y) | (x & z) | (y & z);
  assign c   = {maj[PW-2:0], 1'b0};

  logic [PW+1:0] in_sum, out_sum;
  assign in_sum  = (PW+2)'(x) + (PW+2)'(y) + (PW+2)'(z);
  assign out_sum = (PW+2)'(s) + (PW+2)'(c);

  always_comb begin
    if (!$isunknown({x, y, z})) begin
      // R3: value preserved across the 3:2 cell
      assert_csa_sum_R3: assert (in_sum == out_sum);
      // R5: the carry dropped at the top column is always zero
      assert_no_overflow_R5: assert (maj[PW-1] == 1'b0);
    end
  end
endmodule

// File: rtl/wt_csa_layer.sv
module wt_csa_layer #(
  parameter int PW   = 16,
  parameter int NIN  = 8,
  localparam int NGRP = NIN / 3,
  localparam int NREM = NIN % 3,
  localparam int NOUT = 2 * NGRP + NREM
) (
  input  logic [NIN*PW-1:0]  ops_in,
  output logic [NOUT*PW-1:0] ops_out
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    wt_csa_row #(.PW(PW)) u_row (
      .x (ops_in[(3*g)*PW   +: PW]),
      .y (ops_in[(3*g+1)*PW +: PW]),
      .z (ops_in[(3*g+2)*PW +: PW]),
      .s (ops_out[(2*g)*PW   +: PW]),
      .c (ops_out[(2*g+1)*PW +: PW])
    );
  end

  // R4: leftover operands pass to the next layer untouched
  for (genvar r = 0; r < NREM; r++) begin : g_pass
    assign ops_out[(2*NGRP+r)*PW +: PW] = ops_in[(3*NGRP+r)*PW +: PW];
  end
endmodule

// File: rtl/wt_cpa.sv
module wt_cpa #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  output logic [PW-1:0] s
);
  logic [PW-1:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < PW; i++) begin : g_bit
    assign s[i] = x[i] ^ y[i] ^ cy[i];
    if (i < PW - 1) begin : g_cy
      assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
    end
  end
endmodule

// File: rtl/wtree_mult.sv
module wtree_mult #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  import wt_pkg::*;

  localparam int PW    = 2 * W;
  localparam int NL    = num_layers(W);
  localparam int TOTAL = pool_off(W, NL + 1);
  localparam int LAST  = pool_off(W, NL);

  // every layer's operands laid end to end
  logic [TOTAL*PW-1:0] pool;
  logic [PW-1:0]       sum;

  wt_ppgen #(.W(W), .PW(PW)) u_ppgen (
    .a  (a),
    .b  (b),
    .pp (pool[W*PW-1:0])
  );

  for (genvar l = 0; l < NL; l++) begin : g_layer
    localparam int NI = ops_at(W, l);
    localparam int NO = ops_next(NI);
    localparam int OI = pool_off(W, l);
    localparam int OO = pool_off(W, l + 1);
    wt_csa_layer #(.PW(PW), .NIN(NI)) u_layer (
      .ops_in  (pool[OI*PW +: NI*PW]),
      .ops_out (pool[OO*PW +: NO*PW])
    );
  end

  wt_cpa #(.PW(PW)) u_cpa (
    .x (pool[LAST*PW +: PW]),
    .y (pool[(LAST+1)*PW +: PW]),
    .s (sum)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) p <= '0;
      else     p <= sum;
    end

    assert_reset_clears_R7: assert property (@(posedge clk)
      rst |=> (p == '0));

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) == 1'b0) |->
        (p == (PW'($past(a)) * PW'($past(b)))));
  end else begin : g_comb
    assign p = sum;

    assert_rst_ignored_R7: assert property (@(posedge clk)
      rst |-> (p == (PW'(a) * PW'(b))));

    always_comb begin
      if (!$isunknown({a, b}))
        assert_product_R1: assert (p == (PW'(a) * PW'(b)));
    end
  end
endmodule

// File: tb/wtree_mult_tb.sv
module wtree_mult_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [3:0]  a4, b4;
  logic [7:0]  a8, b8;
  logic [15:0] a16, b16;
  logic [7:0]  p4;
  logic [15:0] p8;
  logic [31:0] p16;

  wtree_mult #(.W(4),  .REG_OUT(1'b0)) u_dut4  (.clk(clk), .rst(rst), .a(a4),  .b(b4),  .p(p4));
  wtree_mult #(.W(8),  .REG_OUT(1'b1)) u_dut   (.clk(clk), .rst(rst), .a(a8),  .b(b8),  .p(p8));
  wtree_mult #(.W(16), .REG_OUT(1'b1)) u_dut16 (.clk(clk), .rst(rst), .a(a16), .b(b16), .p(p16));

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  function automatic logic [31:0] mul_ref(input logic [31:0] x, input logic [31:0] y);
    return x * y;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, check the combinational unit 1 ns later,
  // check the registered units at the next falling edge
  task automatic step(input logic [3:0] x4, input logic [3:0] y4,
                      input logic [7:0] x8, input logic [7:0] y8,
                      input logic [15:0] x16, input logic [15:0] y16,
                      input logic r, input string tag);
    logic [31:0] e8, e16;
    @(negedge clk);
    a4 = x4; b4 = y4; a8 = x8; b8 = y8; a16 = x16; b16 = y16; rst = r;
    #1;
    chk({tag, " w4"}, {24'd0, p4}, mul_ref({28'd0, x4}, {28'd0, y4}));
    e8  = r ? 32'd0 : mul_ref({24'd0, x8}, {24'd0, y8});
    e16 = r ? 32'd0 : mul_ref({16'd0, x16}, {16'd0, y16});
    @(negedge clk);
    chk({tag, " w8"},  {16'd0, p8}, e8);
    chk({tag, " w16"}, p16, e16);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    a4 = 4'd3; b4 = 4'd5; a8 = 8'hA5; b8 = 8'h3C; a16 = 16'h1234; b16 = 16'hBEEF;
    repeat (3) @(negedge clk);
    // R7: register held at zero during reset
    chk("R7 reset w8",  {16'd0, p8}, 32'd0);
    chk("R7 reset w16", p16, 32'd0);
    // R7: combinational unit ignores rst
    chk("R7 comb during rst", {24'd0, p4}, 32'd15);

    // R8: zero operands
    step(4'd0, 4'hF, 8'd0, 8'hFF, 16'd0, 16'hFFFF, 1'b0, "R8 zero a");
    step(4'hF, 4'd0, 8'hFF, 8'd0, 16'hFFFF, 16'd0, 1'b0, "R8 zero b");
    // R5: all ones, longest carry chains
    step(4'hF, 4'hF, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 1'b0, "R5 all ones");
    // R2: single multiplier bit selects one row
    for (int k = 0; k < 16; k++)
      step(4'(4'd1 << (k % 4)), 4'hB, 8'hD7, 8'(8'd1 << (k % 8)),
           16'hE3A9, 16'(16'd1 << k), 1'b0, "R2 single row");
    // R3: alternating patterns force many coincident carries
    step(4'h5, 4'hA, 8'h55, 8'hAA, 16'h5555, 16'hAAAA, 1'b0, "R3 alt");
    step(4'hA, 4'hF, 8'hAA, 8'hFF, 16'hAAAA, 16'hFFFF, 1'b0, "R3 alt full");
    step(4'h7, 4'h7, 8'h7F, 8'h81, 16'h7FFF, 16'h8001, 1'b0, "R3 mixed");
    // R6: back-to-back vectors show one-cycle latency
    step(4'h1, 4'h1, 8'h02, 8'h03, 16'h0100, 16'h0100, 1'b0, "R6 latency a");
    step(4'h2, 4'h2, 8'h10, 8'h11, 16'hFF00, 16'h00FF, 1'b0, "R6 latency b");
    // R7: reset in mid run clears register, not the comb unit
    step(4'h9, 4'hD, 8'hC3, 8'h5A, 16'hCAFE, 16'hF00D, 1'b1, "R7 mid reset");
    step(4'h9, 4'hD, 8'hC3, 8'h5A, 16'hCAFE, 16'hF00D, 1'b0, "R7 after reset");

    // R1/R4: exhaustive 4x4 (one pass-through operand) with random wide pairs
    for (int i = 0; i < 256; i++)
      step(4'(i >> 4), 4'(i), 8'($urandom), 8'($urandom),
           16'($urandom), 16'($urandom), 1'b0, "R1 R4 sweep");
    // R1: extra random wide vectors
    for (int i = 0; i < 200; i++)
      step(4'($urandom), 4'($urandom), 8'($urandom), 8'($urandom),
           16'($urandom), 16'($urandom), 1'b0, "R1 random");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule